// File: doc/BRIEF.md
# USB Bus Turnaround Timeout Timer

This block times the quiet gap on a USB bus between the end of one packet and the start of the reply to it. It watches a two-bit receive line-state value from a transceiver, a speed select and a window-size select. When the protocol engine raises `arm`, the block waits for the event that marks the end of a packet. It then counts clock cycles until either the event that marks the start of a packet arrives or the chosen limit runs out. A reply that starts in time gives a one-cycle `resp_pulse`. A window that expires gives a one-cycle `tmo_pulse` and sets the sticky `failed_sts` bit. The engine reads that bit to decide whether to issue the next token, and clears it with `sts_clr`.

At full or low speed, the gap begins at the SE0-to-J edge that ends an end-of-packet and ends at the J-to-K edge of a start-of-packet. At high speed, the gap begins when the line enters squelch and ends when the line leaves squelch. The block holds four limits in 60 MHz cycles, one for each combination of speed and window size: a short window for the one-way turnaround figure and a long window for the full round trip. It does not decode packets, check CRC or schedule retries.

The control FSM has four states. IDLE means not armed. WAIT means armed and looking for a start event. COUNT means the gap is being timed. EXPIRED means the window has run out and the block is waiting for the next packet end. Its transitions are: IDLE→WAIT (arm), IDLE/WAIT/EXPIRED→COUNT (arm with a start event, which captures the limit and clears the count), COUNT→WAIT (reply start: `resp_pulse`), COUNT→EXPIRED (limit reached: `tmo_pulse`), and any→IDLE (arm low).

Top module: `usb_turnaround_timer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `tmo_pulse`, `resp_pulse` and `failed_sts` are 0. The FSM is in IDLE and the remembered line state is J.
- R2: Line-state encoding is 00 = SE0/squelch, 01 = J, 10 = K. With `hs_sel`=0, a sample of J right after a sample of SE0 is a start event. A sample of K right after a sample of J is a stop event.
- R3: With `hs_sel`=1, a sample of 00 after a J or K sample is a start event. A J or K sample after a 00 sample is a stop event.
- R4: Let the start event be sampled at clock edge E. If there is no stop event, `tmo_pulse` is 1 for exactly one cycle, after edge E+L. L is 38 (full speed, `long_win`=0), 90 (full speed, `long_win`=1), 24 (high speed, `long_win`=0) or 102 (high speed, `long_win`=1).
- R5: A stop event sampled at edge E+k with 1 ≤ k ≤ L gives `resp_pulse` for one cycle after that edge and no `tmo_pulse`. At k = L the reply wins over the timeout.
- R6: Sampling `arm` low returns the FSM to IDLE with no pulse. Line-state events sampled while `arm` is low produce neither pulse.
- R7: The line-state value 11 is ignored. It is neither an event nor stored as the previous sample, so SE0, 11, J is still a full-speed start event.
- R8: `failed_sts` becomes 1 on the same edge as `tmo_pulse` and stays 1 until `sts_clr` is sampled high. A timeout and a clear on the same edge leave it set.
- R9: In EXPIRED, stop events give no `resp_pulse`. A new start event restarts the count from zero.
- R10: The limit is captured at the start event. Changing `hs_sel` or `long_win` during COUNT does not move the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_st | input | 2 | Receive line state: 00 SE0/squelch, 01 J, 10 K, 11 ignored |
| hs_sel | input | 1 | 1 = high-speed event rules and limits |
| long_win | input | 1 | 1 = round-trip window, 0 = one-way turnaround window |
| arm | input | 1 | Engine is waiting for a reply |
| sts_clr | input | 1 | Clears `failed_sts` |
| tmo_pulse | output | 1 | One-cycle timeout indication |
| resp_pulse | output | 1 | One-cycle reply-started indication |
| failed_sts | output | 1 | Sticky failed-transaction bit |

## Verification
Two pairs of functions can land on the same edge. A reply start can coincide with the count reaching its limit. A timeout can coincide with a software clear of the status bit. The bench provokes the first case by driving the K (or non-squelch) sample on exactly the L-th cycle after the start event; it expects `resp_pulse` high, `tmo_pulse` low and `failed_sts` unchanged. It provokes the second case by raising `sts_clr` in the cycle whose edge produces the timeout; it expects `failed_sts` to stay set. Random traffic also reaches both cases, and a cycle-level reference built from the requirements judges them.

// File: rtl/ta_pkg.sv
package ta_pkg;
    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_BAD = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_COUNT,
        ST_EXPIRED
    } ta_state_e;
endpackage

// File: rtl/ta_line_events.sv
module ta_line_events
    import ta_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_st,
    input  logic       hs_sel,
    output logic       start_ev,
    output logic       stop_ev
);
    logic [1:0] prev_q;
    logic       cur_valid;
    logic       fs_start, fs_stop, hs_start, hs_stop;

    assign cur_valid = (line_st != LS_BAD);

    // Remember the last meaningful sample; the value 11 is skipped (R7)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= LS_J;
        else if (cur_valid)
            prev_q <= line_st;
    end

    always_comb begin
        fs_start = (prev_q == LS_SE0) && (line_st == LS_J);
        fs_stop  = (prev_q == LS_J)   && (line_st == LS_K);
        hs_start = (prev_q != LS_SE0) && (line_st == LS_SE0);
        hs_stop  = (prev_q == LS_SE0) && cur_valid && (line_st != LS_SE0);
        start_ev = hs_sel ? hs_start : fs_start;
        stop_ev  = hs_sel ? hs_stop  : fs_stop;
    end

    a_r7_bad_is_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        (line_st == LS_BAD) |-> (!start_ev && !stop_ev));
    a_r2_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_ev && stop_ev));
endmodule

// File: rtl/ta_limit_sel.sv
module ta_limit_sel #(
    parameter int FS_SHORT = 38,
    parameter int FS_LONG  = 90,
    parameter int HS_SHORT = 24,
    parameter int HS_LONG  = 102,
    parameter int CW       = 7
) (
    input  logic          hs_sel,
    input  logic          long_win,
    output logic [CW-1:0] lim
);
    localparam int NLIM = 4;
    logic [CW-1:0] table_v [NLIM];

    // Table index = {hs_sel, long_win}
    for (genvar i = 0; i < NLIM; i++) begin : g_tab
        localparam int VAL = (i == 0) ? FS_SHORT :
                             (i == 1) ? FS_LONG  :
                             (i == 2) ? HS_SHORT : HS_LONG;
        assign table_v[i] = CW'(VAL);
    end

    assign lim = table_v[{hs_sel, long_win}];
endmodule

// File: rtl/ta_window_counter.sv
module ta_window_counter #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] lim_in,
    input  logic          run,
    output logic          hit
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_q;

    // Limit is latched at the start event (R10)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= CW'(1);
        end else if (load) begin
            cnt_q <= '0;
            lim_q <= lim_in;
        end else if (run) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign hit = run && (cnt_q == lim_q - CW'(1));

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < lim_q));
endmodule

// File: rtl/usb_turnaround_timer.sv
module usb_turnaround_timer
    import ta_pkg::*;
#(
    parameter int FS_SHORT_CYC = 38,
    parameter int FS_LONG_CYC  = 90,
    parameter int HS_SHORT_CYC = 24,
    parameter int HS_LONG_CYC  = 102
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_st,
    input  logic       hs_sel,
    input  logic       long_win,
    input  logic       arm,
    input  logic       sts_clr,
    output logic       tmo_pulse,
    output logic       resp_pulse,
    output logic       failed_sts
);
    localparam int MAX_FS  = (FS_SHORT_CYC > FS_LONG_CYC) ? FS_SHORT_CYC : FS_LONG_CYC;
    localparam int MAX_HS  = (HS_SHORT_CYC > HS_LONG_CYC) ? HS_SHORT_CYC : HS_LONG_CYC;
    localparam int MAX_LIM = (MAX_FS > MAX_HS) ? MAX_FS : MAX_HS;
    localparam int CW      = $clog2(MAX_LIM + 1);

    ta_state_e     state, nxt;
    logic          start_ev, stop_ev, hit;
    logic          take_start, do_resp, do_tmo;
    logic [CW-1:0] lim_sel;

    ta_line_events u_ev (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_st  (line_st),
        .hs_sel   (hs_sel),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    ta_limit_sel #(
        .FS_SHORT (FS_SHORT_CYC),
        .FS_LONG  (FS_LONG_CYC),
        .HS_SHORT (HS_SHORT_CYC),
        .HS_LONG  (HS_LONG_CYC),
        .CW       (CW)
    ) u_lim (
        .hs_sel   (hs_sel),
        .long_win (long_win),
        .lim      (lim_sel)
    );

    ta_window_counter #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (take_start),
        .lim_in (lim_sel),
        .run    (state == ST_COUNT),
        .hit    (hit)
    );

    // Next-state decision
    always_comb begin
        nxt        = state;
        take_start = 1'b0;
        do_resp    = 1'b0;
        do_tmo     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (arm && start_ev) begin
                    nxt        = ST_COUNT;
                    take_start = 1'b1;
                end else if (arm) begin
                    nxt = ST_WAIT;
                end
            end
            ST_WAIT, ST_EXPIRED: begin
                if (!arm) begin
                    nxt = ST_IDLE;
                end else if (start_ev) begin
                    nxt        = ST_COUNT;
                    take_start = 1'b1;
                end
            end
            ST_COUNT: begin
                if (!arm) begin
                    nxt = ST_IDLE;
                end else if (stop_ev) begin
                    nxt     = ST_WAIT;
                    do_resp = 1'b1;
                end else if (hit) begin
                    nxt    = ST_EXPIRED;
                    do_tmo = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_pulse  <= 1'b0;
            resp_pulse <= 1'b0;
            failed_sts <= 1'b0;
        end else begin
            tmo_pulse  <= do_tmo;
            resp_pulse <= do_resp;
            if (do_tmo)       failed_sts <= 1'b1;
            else if (sts_clr) failed_sts <= 1'b0;
        end
    end

    a_r4_tmo_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse |=> !tmo_pulse);
    a_r5_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(tmo_pulse && resp_pulse));
    a_r6_disarm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (!tmo_pulse && !resp_pulse));
    a_r8_fail_with_tmo: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse |-> failed_sts);
    a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (failed_sts && !sts_clr) |=> failed_sts);
    a_r9_resp_only_counting: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COUNT) |=> !resp_pulse);
endmodule

// File: tb/sim_usb_turnaround_timer.sv
`timescale 1ns/1ps
module sim_usb_turnaround_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] line_st = 2'b01;
    logic       hs_sel = 1'b0;
    logic       long_win = 1'b0;
    logic       arm = 1'b0;
    logic       sts_clr = 1'b0;
    logic       tmo_pulse, resp_pulse, failed_sts;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit rnd_mode = 1'b0;

    always #2.5 clk = ~clk;

    usb_turnaround_timer u0 (
        .clk(clk), .rst_n(rst_n), .line_st(line_st), .hs_sel(hs_sel),
        .long_win(long_win), .arm(arm), .sts_clr(sts_clr),
        .tmo_pulse(tmo_pulse), .resp_pulse(resp_pulse), .failed_sts(failed_sts)
    );

    // ---------- requirement-derived helpers ----------
    function automatic int exp_limit(input logic hs, input logic lw);
        if (hs) return lw ? 102 : 24;   // R4
        return lw ? 90 : 38;
    endfunction
    function automatic bit is_start(input logic [1:0] p, input logic [1:0] c, input logic hs);
        if (hs) return (c == 2'b00) && (p != 2'b00);       // R3
        return (p == 2'b00) && (c == 2'b01);                // R2
    endfunction
    function automatic bit is_stop(input logic [1:0] p, input logic [1:0] c, input logic hs);
        if (hs) return (p == 2'b00) && (c == 2'b01 || c == 2'b10);
        return (p == 2'b01) && (c == 2'b10);
    endfunction

    // ---------- cycle-level reference ----------
    int m_st, m_cnt, m_lim, ns;
    logic [1:0] m_prev;
    bit m_tmo, m_resp, m_fail, s, p, t, r, ld;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_lim = 1; m_prev = 2'b01;
            m_tmo = 0; m_resp = 0; m_fail = 0;
        end else begin
            s = is_start(m_prev, line_st, hs_sel);
            p = is_stop(m_prev, line_st, hs_sel);
            t = 0; r = 0; ld = 0; ns = m_st;
            if (!arm) ns = 0;
            else case (m_st)
                0: if (s) ld = 1; else ns = 1;
                1, 3: if (s) ld = 1;
                2: if (p) begin r = 1; ns = 1; end
                   else if (m_cnt == m_lim - 1) begin t = 1; ns = 3; end
                default: ns = 0;
            endcase
            if (ld) begin ns = 2; m_cnt = 0; m_lim = exp_limit(hs_sel, long_win); end
            else if (m_st == 2) m_cnt = m_cnt + 1;
            if (t) m_fail = 1; else if (sts_clr) m_fail = 0;
            m_tmo = t; m_resp = r;
            if (line_st != 2'b11) m_prev = line_st;
            m_st = ns;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 model tmo_pulse", tmo_pulse, m_tmo);
            check("R5 model resp_pulse", resp_pulse, m_resp);
            check("R8 model failed_sts", failed_sts, m_fail);
        end
    end

    task automatic tick(input logic [1:0] ls);
        line_st = ls;
        if (rnd_mode) begin
            sts_clr = ($urandom_range(0, 99) < 3);
            if ($urandom_range(0, 199) == 0) arm = ~arm;
        end
        @(negedge clk);
    endtask
    task automatic hold(input int n, input logic [1:0] ls);
        for (int i = 0; i < n; i++) tick(ls);
    endtask
    task automatic clear_sts();
        sts_clr = 1'b1; tick(line_st); sts_clr = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin : watchdog
        #(5.0 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset tmo", tmo_pulse, 0);
        check("R1 reset resp", resp_pulse, 0);
        check("R1 reset failed", failed_sts, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release failed", failed_sts, 0);

        // R2: full-speed reply in time
        arm = 1; hs_sel = 0; long_win = 0;
        tick(2'b00); tick(2'b01);
        hold(5, 2'b01);
        tick(2'b10);
        check("R2 fs resp_pulse", resp_pulse, 1);
        tick(2'b10);
        check("R2 resp one cycle", resp_pulse, 0);
        tick(2'b01);

        // R4 + R8: full-speed short timeout at 38
        tick(2'b00); tick(2'b01);
        hold(37, 2'b01);
        check("R4 fs short before limit", tmo_pulse, 0);
        tick(2'b01);
        check("R4 fs short at limit", tmo_pulse, 1);
        check("R8 failed set with tmo", failed_sts, 1);
        tick(2'b01);
        check("R4 tmo one cycle", tmo_pulse, 0);
        hold(20, 2'b01);
        check("R8 failed sticky", failed_sts, 1);
        clear_sts();
        check("R8 cleared", failed_sts, 0);

        // R3 + R4: high-speed long timeout at 102
        hs_sel = 1; long_win = 1;
        tick(2'b01); tick(2'b00);
        hold(101, 2'b00);
        check("R4 hs long before limit", tmo_pulse, 0);
        tick(2'b00);
        check("R3 hs long at limit", tmo_pulse, 1);
        clear_sts();

        // R3: high-speed reply (squelch left with K)
        tick(2'b10); tick(2'b00);
        hold(3, 2'b00);
        tick(2'b10);
        check("R3 hs resp_pulse", resp_pulse, 1);

        // R5: reply exactly at limit (fs long, 90) wins
        hs_sel = 0; long_win = 1;
        tick(2'b01); tick(2'b00); tick(2'b01);
        hold(89, 2'b01);
        tick(2'b10);
        check("R5 resp at limit", resp_pulse, 1);
        check("R5 no tmo at limit", tmo_pulse, 0);
        check("R5 failed untouched", failed_sts, 0);
        tick(2'b01);

        // R6: disarmed events ignored
        arm = 0; long_win = 0;
        tick(2'b00); tick(2'b01); hold(3, 2'b01); tick(2'b10);
        check("R6 no resp while disarmed", resp_pulse, 0);
        tick(2'b01); hold(60, 2'b01);
        check("R6 no failed while disarmed", failed_sts, 0);
        // R6: arm drop mid-count clears without timeout
        arm = 1;
        tick(2'b00); tick(2'b01); hold(10, 2'b01);
        arm = 0; tick(2'b01);
        arm = 1; hold(60, 2'b01);
        check("R6 no tmo after disarm", failed_sts, 0);

        // R7: value 11 ignored between SE0 and J
        tick(2'b00); tick(2'b11); tick(2'b01);
        hold(37, 2'b01);
        check("R7 start through 11 pre", tmo_pulse, 0);
        // R8: clear and timeout on same edge -> stays set
        sts_clr = 1; tick(2'b01); sts_clr = 0;
        check("R7 start through 11 tmo", tmo_pulse, 1);
        check("R8 set wins over clear", failed_sts, 1);

        // R9: in EXPIRED a K is not a reply; restart works
        tick(2'b10);
        check("R9 no resp when expired", resp_pulse, 0);
        clear_sts();
        tick(2'b01); tick(2'b00); tick(2'b01);
        hold(37, 2'b01);
        tick(2'b01);
        check("R9 restart timeout", tmo_pulse, 1);
        clear_sts();

        // R10: limit captured at start
        long_win = 0;
        tick(2'b00); tick(2'b01);
        long_win = 1; hs_sel = 1;
        hold(37, 2'b01);
        check("R10 pre", tmo_pulse, 0);
        tick(2'b01);
        check("R10 captured limit", tmo_pulse, 1);
        hs_sel = 0; long_win = 0;
        clear_sts();

        // Random traffic against the reference
        rnd_mode = 1;
        for (int seg = 0; seg < 400; seg++) begin
            int gap;
            if ($urandom_range(0, 7) == 0) hs_sel = $urandom_range(0, 1);
            if ($urandom_range(0, 5) == 0) long_win = $urandom_range(0, 1);
            if ($urandom_range(0, 9) == 0) arm = 1;
            gap = $urandom_range(0, 110);
            if (!hs_sel) begin
                hold($urandom_range(1, 3), 2'b00);
                if ($urandom_range(0, 9) == 0) tick(2'b11);
                hold(gap, 2'b01);
                if ($urandom_range(0, 3) != 0) hold($urandom_range(1, 4), 2'b10);
                tick(2'b01);
            end else begin
                hold($urandom_range(1, 3), $urandom_range(0, 1) ? 2'b01 : 2'b10);
                hold(gap, 2'b00);
                if ($urandom_range(0, 9) == 0) tick(2'b11);
                tick($urandom_range(0, 1) ? 2'b01 : 2'b10);
            end
        end
        rnd_mode = 0; sts_clr = 0;
        hold(3, 2'b01);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule